// File: doc/BRIEF.md
# Daisy-Chainable Status Register Serial Slave

This block is the serial command and status port of a two-channel switch controller. A host frames a transfer with an active-low chip select and clocks 8-bit command words in on the data input (mode 0: input sampled on the rising serial clock, output changed on the falling serial clock). The serial clock, chip select and data input are synchronized into the system clock domain and handled with edge detection. While the command bits go in, a status byte comes out. Its content depends on two things: the channel bit of the last accepted command and a sticky status-select field. Once the status byte has been sent, the output repeats the incoming bits eight clocks later. Several devices can therefore share one chain, and the host can read back what it sent.

A frame takes effect only when chip select rises after a nonzero whole number of bytes. In that case the last byte received is decoded as a command. Bit 7 is the channel bit, bits 6:4 are the register address and bits 3:0 are the data. Any other frame is dropped without trace. Fault events arrive as input bits and are held in sticky per-channel latches. These latches are reloaded from the live fault inputs after each accepted frame. The output driver is enabled only while chip select is low.

Top module: `hss_spi_status`

## Requirements
- R1: `so_oe` is 0 whenever chip select has been high for the last three system clocks, and 1 while a frame is in progress. `so_oe` is 0 after reset.
- R2: On the falling edge of chip select the status byte is captured. It is then sent most significant bit first: bit 7 is on `so` before the first rising serial clock, and each falling serial clock moves to the next bit. `si` is sampled on rising serial clocks.
- R3: After the first eight bits, `so` returns the `si` bits of the current frame in the order they arrived, eight serial clocks later.
- R4: When chip select rises, the frame is accepted only if the number of rising serial clocks is nonzero and a multiple of 8. On acceptance, the last 8 bits received are decoded as the command.
- R5: A rejected frame, including one with no clocks, changes no register, no select field, no channel bit and no fault latch.
- R6: Command decode uses bit 7 as the channel (0 = channel 0) and bits 6:4 as the address. Address 000 writes the select field from data[2:0]. Address 001 writes the channel's {sense enable, software input} from data[1:0]. Address 010 writes the channel's 4-bit over-current level. Address 011 writes the channel's 4-bit configuration. Addresses 100 to 111 write nothing.
- R7: Bit 7 of the status byte equals bit 7 of the last accepted command. That bit also chooses which channel the per-channel status describes.
- R8: With select 000, status bits 6:0 are the fault latch of the chosen channel.
- R9: With select 001, status bits 6:0 are {000, sense1, swin1, sense0, swin0}.
- R10: With select 010, status bits 6:0 are {000, over-current level of the chosen channel}. With select 011 they are {000, configuration of the chosen channel}. Any other select gives zero.
- R11: A fault latch bit is set by any cycle in which its input is high and is held until an accepted frame completes. It is then reloaded from the current inputs.
- R12: After reset the channel bit, the select field, all registers and all fault latches are zero, so the first frame returns the channel-0 fault byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low, asynchronous |
| sclk | input | 1 | Serial clock, asynchronous |
| si | input | 1 | Serial data in |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for the serial data out pin |
| flt_ch0 | input | 7 | Fault event bits, channel 0 |
| flt_ch1 | input | 7 | Fault event bits, channel 1 |
| sense_en | output | 2 | Current-sense enable, bit n = channel n |
| sw_in | output | 2 | Software input, bit n = channel n |
| oc_lvl | output | 8 | Over-current level, [7:4] channel 1, [3:0] channel 0 |
| cfg | output | 8 | Channel configuration, [7:4] channel 1, [3:0] channel 0 |

## Verification
Corruption of the channel bit or the select field does not appear at once. It shows up only in the status byte of the next frame, so each test sends a command and checks its effect one frame later. A rejected frame that wrongly commits would change the register outputs within a few clocks of chip select rising. A missed fault-latch release would show as a fault byte that stays set in the frame after a commit. A broken echo path shows on `so` from bit nine of a long frame onward.

// File: rtl/hss_spi_pkg.sv
package hss_spi_pkg;
  localparam int WORD_W = 8;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 4;
  localparam int FLT_W  = 7;
  localparam int N_CH   = 2;

  localparam logic [ADDR_W-1:0] ADR_SEL  = 3'b000;
  localparam logic [ADDR_W-1:0] ADR_CTRL = 3'b001;
  localparam logic [ADDR_W-1:0] ADR_OCL  = 3'b010;
  localparam logic [ADDR_W-1:0] ADR_CFG  = 3'b011;

  typedef struct packed {
    logic              ch;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } cmd_t;
endpackage

// File: rtl/hss_spi_sync.sv
module hss_spi_sync #(
  parameter int               STAGES  = 2,
  parameter int               WIDTH   = 3,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q,
  output logic [WIDTH-1:0] rise,
  output logic [WIDTH-1:0] fall
);
  logic [STAGES-1:0][WIDTH-1:0] pipe;
  logic [WIDTH-1:0]             prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      pipe <= {STAGES{RST_VAL}};
      prev <= RST_VAL;
    end else begin
      pipe[0] <= d;
      prev    <= pipe[STAGES-1];
      for (int s = 1; s < STAGES; s++) pipe[s] <= pipe[s-1];
    end
  end

  assign q    = pipe[STAGES-1];
  assign rise = pipe[STAGES-1] & ~prev;
  assign fall = ~pipe[STAGES-1] & prev;
endmodule

// File: rtl/hss_spi_framer.sv
module hss_spi_framer
  import hss_spi_pkg::*;
#(
  parameter int W = WORD_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cs_fall,
  input  logic         cs_rise,
  input  logic         cs_act,
  input  logic         sclk_rise,
  input  logic         sclk_fall,
  input  logic         si_bit,
  input  logic [W-1:0] load_byte,
  output logic         so_bit,
  output logic         so_oe,
  output logic         commit,
  output logic [W-1:0] rx_byte
);
  localparam int CNT_W = $clog2(W);

  logic [W-1:0]     sh;
  logic [CNT_W-1:0] cnt;
  logic             seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh     <= '0;
      cnt    <= '0;
      seen   <= 1'b0;
      so_bit <= 1'b0;
      so_oe  <= 1'b0;
      commit <= 1'b0;
    end else begin
      so_oe  <= cs_act;
      commit <= 1'b0;
      if (cs_fall) begin
        sh     <= load_byte;
        so_bit <= load_byte[W-1];
        cnt    <= '0;
        seen   <= 1'b0;
      end else if (cs_act) begin
        if (sclk_rise) begin
          sh   <= {sh[W-2:0], si_bit};
          cnt  <= cnt + 1'b1;
          seen <= 1'b1;
        end
        if (sclk_fall) so_bit <= sh[W-1];
      end
      if (cs_rise) commit <= seen && (cnt == '0);
    end
  end

  assign rx_byte = sh;
endmodule

// File: rtl/hss_spi_regs.sv
module hss_spi_regs
  import hss_spi_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        commit,
  input  cmd_t                        cmd,
  input  logic [N_CH-1:0][FLT_W-1:0]  flt_in,
  output logic [WORD_W-1:0]           status,
  output logic                        ch_q,
  output logic [ADDR_W-1:0]           sel_q,
  output logic [N_CH-1:0][FLT_W-1:0]  flt_q,
  output logic [N_CH-1:0]             sense_en,
  output logic [N_CH-1:0]             sw_in,
  output logic [N_CH-1:0][DATA_W-1:0] oc_q,
  output logic [N_CH-1:0][DATA_W-1:0] cfg_q
);
  localparam int PAD_W = WORD_W - 1 - DATA_W;

  always_ff @(posedge clk) begin
    if (rst) begin
      ch_q  <= 1'b0;
      sel_q <= '0;
    end else if (commit) begin
      ch_q <= cmd.ch;
      if (cmd.addr == ADR_SEL) sel_q <= cmd.data[ADDR_W-1:0];
    end
  end

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    logic hit;
    assign hit = commit && (int'(cmd.ch) == g);

    always_ff @(posedge clk) begin
      if (rst) begin
        sense_en[g] <= 1'b0;
        sw_in[g]    <= 1'b0;
        oc_q[g]     <= '0;
        cfg_q[g]    <= '0;
      end else if (hit) begin
        case (cmd.addr)
          ADR_CTRL: begin
            sense_en[g] <= cmd.data[1];
            sw_in[g]    <= cmd.data[0];
          end
          ADR_OCL: oc_q[g]  <= cmd.data;
          ADR_CFG: cfg_q[g] <= cmd.data;
          default: ;
        endcase
      end
    end

    always_ff @(posedge clk) begin
      if (rst)         flt_q[g] <= '0;
      else if (commit) flt_q[g] <= flt_in[g];
      else             flt_q[g] <= flt_q[g] | flt_in[g];
    end
  end

  always_comb begin
    status[WORD_W-1] = ch_q;
    case (sel_q)
      ADR_SEL:  status[WORD_W-2:0] = flt_q[ch_q];
      ADR_CTRL: status[WORD_W-2:0] = {{(WORD_W-5){1'b0}}, sense_en[1], sw_in[1], sense_en[0], sw_in[0]};
      ADR_OCL:  status[WORD_W-2:0] = {{PAD_W{1'b0}}, oc_q[ch_q]};
      ADR_CFG:  status[WORD_W-2:0] = {{PAD_W{1'b0}}, cfg_q[ch_q]};
      default:  status[WORD_W-2:0] = '0;
    endcase
  end
endmodule

// File: rtl/hss_spi_status.sv
module hss_spi_status
  import hss_spi_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              si,
  output logic              so,
  output logic              so_oe,
  input  logic [FLT_W-1:0]  flt_ch0,
  input  logic [FLT_W-1:0]  flt_ch1,
  output logic [N_CH-1:0]   sense_en,
  output logic [N_CH-1:0]   sw_in,
  output logic [2*DATA_W-1:0] oc_lvl,
  output logic [2*DATA_W-1:0] cfg
);
  logic [2:0] s_q, s_rise, s_fall;
  logic       commit;
  logic [WORD_W-1:0] rx_byte, status;
  logic       ch_q;
  logic [ADDR_W-1:0] sel_q;
  logic [N_CH-1:0][FLT_W-1:0]  flt_q;
  logic [N_CH-1:0][DATA_W-1:0] oc_q, cfg_q;

  hss_spi_sync #(.STAGES(SYNC_STAGES), .WIDTH(3), .RST_VAL(3'b010)) u_sync (
    .clk(clk), .rst(rst), .d({si, cs_n, sclk}),
    .q(s_q), .rise(s_rise), .fall(s_fall)
  );

  hss_spi_framer #(.W(WORD_W)) u_framer (
    .clk(clk), .rst(rst),
    .cs_fall(s_fall[1]), .cs_rise(s_rise[1]), .cs_act(~s_q[1]),
    .sclk_rise(s_rise[0]), .sclk_fall(s_fall[0]), .si_bit(s_q[2]),
    .load_byte(status), .so_bit(so), .so_oe(so_oe),
    .commit(commit), .rx_byte(rx_byte)
  );

  hss_spi_regs u_regs (
    .clk(clk), .rst(rst), .commit(commit), .cmd(cmd_t'(rx_byte)),
    .flt_in({flt_ch1, flt_ch0}), .status(status),
    .ch_q(ch_q), .sel_q(sel_q), .flt_q(flt_q),
    .sense_en(sense_en), .sw_in(sw_in), .oc_q(oc_q), .cfg_q(cfg_q)
  );

  assign oc_lvl = oc_q;
  assign cfg    = cfg_q;
endmodule

// File: rtl/hss_spi_status_chk.sv
module hss_spi_status_chk
  import hss_spi_pkg::*;
(
  input logic                       clk,
  input logic                       rst,
  input logic                       cs_n,
  input logic                       so_oe,
  input logic                       commit,
  input logic                       ch_q,
  input logic [ADDR_W-1:0]          sel_q,
  input logic [N_CH-1:0][FLT_W-1:0] flt_q,
  input logic [N_CH-1:0]            sense_en,
  input logic [N_CH-1:0]            sw_in,
  input logic [2*DATA_W-1:0]        oc_lvl,
  input logic [2*DATA_W-1:0]        cfg
);
  AST_SO_HIZ_IDLE: assert property (@(posedge clk) disable iff (rst)
    ($past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3)) |-> !so_oe); // R1

  AST_COMMIT_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
    commit |-> $past(so_oe)); // R4

  AST_REGS_HOLD: assert property (@(posedge clk) disable iff (rst)
    !commit |=> $stable({ch_q, sel_q, sense_en, sw_in, oc_lvl, cfg})); // R5

  AST_FLT_STICKY: assert property (@(posedge clk) disable iff (rst)
    !commit |=> ((flt_q & $past(flt_q)) == $past(flt_q))); // R11

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (!ch_q && sel_q == '0 && flt_q == '0 && oc_lvl == '0 && cfg == '0)); // R12
endmodule

bind hss_spi_status hss_spi_status_chk u_chk (
  .clk(clk), .rst(rst), .cs_n(cs_n), .so_oe(so_oe), .commit(commit),
  .ch_q(ch_q), .sel_q(sel_q), .flt_q(flt_q),
  .sense_en(sense_en), .sw_in(sw_in), .oc_lvl(oc_lvl), .cfg(cfg)
);

// File: tb/tb_hss_spi_status.sv
module tb_hss_spi_status;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 12;
  // {command byte, status byte expected back in the same frame}
  localparam logic [15:0] VEC [NV] = '{
    16'h13_00, 16'h01_00, 16'h92_03, 16'h02_8B,
    16'hA5_00, 16'h2C_85, 16'h03_0C, 16'hB9_00,
    16'h85_89, 16'h70_80, 16'h00_00, 16'h00_00
  };

  logic clk = 1'b0, rst = 1'b1, cs_n = 1'b1, sclk = 1'b0, si = 1'b0;
  logic [6:0] flt_ch0 = '0, flt_ch1 = '0;
  logic so, so_oe;
  logic [1:0] sense_en, sw_in;
  logic [7:0] oc_lvl, cfg;
  int checks = 0, errors = 0;
  logic [31:0] rx;

  always #(CLK_PERIOD/2) clk = ~clk;

  hss_spi_status dut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .si(si),
    .so(so), .so_oe(so_oe), .flt_ch0(flt_ch0), .flt_ch1(flt_ch1),
    .sense_en(sense_en), .sw_in(sw_in), .oc_lvl(oc_lvl), .cfg(cfg)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [31:0] tx, input int nbits, output logic [31:0] r);
    r = '0;
    cs_n = 1'b0;
    tick(6);
    for (int i = nbits - 1; i >= 0; i--) begin
      si = tx[i];
      tick(4);
      r = {r[30:0], so};
      sclk = 1'b1;
      tick(4);
      sclk = 1'b0;
    end
    tick(2);
    cs_n = 1'b1;
    tick(8);
  endtask

  initial begin
    tick(5);
    chk("R1 reset oe", {31'd0, so_oe}, 32'd0);
    chk("R12 reset regs", {16'd0, oc_lvl, cfg}, 32'd0);
    chk("R12 reset ctrl", {28'd0, sense_en, sw_in}, 32'd0);
    rst = 1'b0;
    tick(4);

    // R2 R6 R7 R8 R9 R10 R12: table walk
    for (int v = 0; v < NV; v++) begin
      xfer({24'd0, VEC[v][15:8]}, 8, rx);
      chk($sformatf("R2/R7-R10 vec %0d", v), rx[7:0], {24'd0, VEC[v][7:0]});
    end
    chk("R6 sense", {30'd0, sense_en}, 32'h3);
    chk("R6 swin", {30'd0, sw_in}, 32'h1);
    chk("R6 oc", {24'd0, oc_lvl}, 32'h5C);
    chk("R6 cfg", {24'd0, cfg}, 32'h90);

    // R11 latch, R3 echo, R4 multi-byte commit
    flt_ch0 = 7'h04; tick(1); flt_ch0 = '0; tick(2);
    xfer(32'h5A81, 16, rx);
    chk("R8 R11 fault byte", {24'd0, rx[15:8]}, 32'h04);
    chk("R3 echo", {24'd0, rx[7:0]}, 32'h5A);
    xfer(32'h80, 8, rx);
    chk("R4 R9 last byte committed", rx, 32'h8B);

    // R5 zero-clock and partial frames
    flt_ch1 = 7'h20; tick(1); flt_ch1 = '0;
    cs_n = 1'b0; tick(6);
    chk("R1 oe active", {31'd0, so_oe}, 32'd1);
    cs_n = 1'b1; tick(4);
    chk("R1 oe idle", {31'd0, so_oe}, 32'd0);
    tick(4);
    xfer(32'h52F, 12, rx);
    chk("R11 latched ch1", {24'd0, rx[11:4]}, 32'hA0);
    chk("R3 partial echo", {28'd0, rx[3:0]}, 32'h5);
    chk("R5 oc unchanged", {24'd0, oc_lvl}, 32'h5C);
    xfer(32'h80, 8, rx);
    chk("R5 latch kept after reject", rx, 32'hA0);
    xfer(32'h00, 8, rx);
    chk("R11 latch released", rx, 32'h80);
    xfer(32'h00, 8, rx);
    chk("R7 channel bit cleared", rx, 32'h00);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule